// File: doc/BRIEF.md
# Digital Feedback Clamp Controller

This block closes the digital half of a feedback black-level clamp for a three-channel video digitizer. Each channel's converted 8-bit sample is compared against a fixed target code while a clamp gate is open. The gate is normally placed on the back porch of the horizontal blanking interval. The result is a three-way pump command. The block asks an external RC node to be charged when the sample sits below target, discharged when it sits above target, and left floating (high impedance) when sample and target agree.

One lane exists per channel, and there are three lanes by default. A per-lane select picks the target code: the brightness (luma) target is 16 and the colour-difference (chroma) target is 128. Each lane's command is registered on the sample clock. It advances only on cycles that carry a valid sample. A closed gate forces the floating state at the next edge, and so does the global clamp-off input. The clamp-off input lets the converter run RGB material with no clamping at all.

Top module: `fb_clamp_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every lane reports the floating state: hiz=1, charge=0, discharge=0.
- R2: With the gate open, clamp-off low and valid high, a sample code below the lane's target makes that lane's charge output 1 (and the others 0) from the next clock edge.
- R3: Under the same conditions, a sample code equal to the target makes the lane float (hiz=1, charge=0, discharge=0) from the next clock edge.
- R4: Under the same conditions, a sample code above the target makes that lane's discharge output 1 (and the others 0) from the next clock edge.
- R5: A lane whose target select is 0 uses target code 16 (binary 00010000). A lane whose target select is 1 uses target code 128 (binary 10000000).
- R6: When the gate is low at a clock edge, every lane floats after that edge, whatever its sample code and valid input.
- R7: When clamp-off is high at a clock edge, every lane floats after that edge. This holds even with the gate open and a valid sample present.
- R8: With the gate open and clamp-off low, a lane whose valid input is low keeps its previous command, whatever its sample code.
- R9: In every cycle, exactly one of charge, discharge and hiz is 1 on each lane.
- R10: Lanes are independent: the code, valid and target select of one lane never change another lane's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clamp_off | input | 1 | Global clamp disable; forces all lanes to float |
| clamp_gate | input | 1 | Clamp window, active high, shared by all lanes |
| smp_code | input | NUM_CH x 8 | Converted sample code per lane; lane i is element i |
| smp_valid | input | NUM_CH | Per-lane strobe that marks a new sample |
| chroma_sel | input | NUM_CH | Per-lane target select: 0 gives 16, 1 gives 128 |
| pump_charge | output | NUM_CH | Per-lane drive-high command (node charges) |
| pump_discharge | output | NUM_CH | Per-lane drive-low command (node discharges) |
| pump_hiz | output | NUM_CH | Per-lane floating indicator (node holds) |

## Verification
Two events can land on the same edge. The clamp gate can close, or clamp-off can rise, on the very edge where a lane presents a valid sample that on its own would charge or discharge the node. The bench provokes both collisions. It first drives a lane into the charge or discharge state. It then presents a valid far-off-target sample in the same cycle that the gate drops, and again in the same cycle that clamp-off rises. Both cases pass only if that lane floats right after the edge, because the forcing condition must win over the comparison.

// File: rtl/clamp_pkg.sv
package clamp_pkg;

    parameter int CODE_W = 8;

    typedef enum logic [1:0] {
        DRV_HOLD = 2'b00,
        DRV_CHG  = 2'b01,
        DRV_DIS  = 2'b10
    } drv_cmd_t;

    typedef struct packed {
        drv_cmd_t cmd;
    } lane_st_t;

endpackage

// File: rtl/clamp_target_sel.sv
module clamp_target_sel #(
    parameter int W          = 8,
    parameter int LUMA_TGT   = 16,
    parameter int CHROMA_TGT = 128
) (
    input  logic         chroma_sel,
    output logic [W-1:0] tgt
);
    localparam logic [W-1:0] LumaCode   = W'(LUMA_TGT);
    localparam logic [W-1:0] ChromaCode = W'(CHROMA_TGT);

    always_comb begin
        tgt = chroma_sel ? ChromaCode : LumaCode;
    end
endmodule

// File: rtl/clamp_lane.sv
module clamp_lane
    import clamp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         off,
    input  logic         gate,
    input  logic         valid,
    input  logic [W-1:0] code,
    input  logic [W-1:0] tgt,
    output logic         charge,
    output logic         discharge,
    output logic         hiz
);
    lane_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (off || !gate) begin
            st_d.cmd = DRV_HOLD;
        end else if (valid) begin
            if (code < tgt) begin
                st_d.cmd = DRV_CHG;
            end else if (code > tgt) begin
                st_d.cmd = DRV_DIS;
            end else begin
                st_d.cmd = DRV_HOLD;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cmd: DRV_HOLD};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        charge    = (st_q.cmd == DRV_CHG);
        discharge = (st_q.cmd == DRV_DIS);
        hiz       = !(charge || discharge);
    end

    p_below_charge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && !off && valid && (code < tgt)) |=> charge);

    p_equal_float_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && !off && valid && (code == tgt)) |=> hiz);

    p_above_discharge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && !off && valid && (code > tgt)) |=> discharge);

    p_gate_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |=> hiz);

    p_clamp_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        off |=> hiz);

    p_stall_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && !off && !valid) |=> $stable({charge, discharge, hiz}));

    p_one_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({charge, discharge, hiz}));
endmodule

// File: rtl/fb_clamp_ctrl.sv
module fb_clamp_ctrl #(
    parameter int NUM_CH     = 3,
    parameter int CODE_W     = 8,
    parameter int LUMA_TGT   = 16,
    parameter int CHROMA_TGT = 128
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clamp_off,
    input  logic                           clamp_gate,
    input  logic [NUM_CH-1:0][CODE_W-1:0]  smp_code,
    input  logic [NUM_CH-1:0]              smp_valid,
    input  logic [NUM_CH-1:0]              chroma_sel,
    output logic [NUM_CH-1:0]              pump_charge,
    output logic [NUM_CH-1:0]              pump_discharge,
    output logic [NUM_CH-1:0]              pump_hiz
);
    logic [NUM_CH-1:0][CODE_W-1:0] tgt_code;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
        clamp_target_sel #(
            .W          (CODE_W),
            .LUMA_TGT   (LUMA_TGT),
            .CHROMA_TGT (CHROMA_TGT)
        ) u_tsel (
            .chroma_sel (chroma_sel[i]),
            .tgt        (tgt_code[i])
        );

        clamp_lane #(
            .W (CODE_W)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .off       (clamp_off),
            .gate      (clamp_gate),
            .valid     (smp_valid[i]),
            .code      (smp_code[i]),
            .tgt       (tgt_code[i]),
            .charge    (pump_charge[i]),
            .discharge (pump_discharge[i]),
            .hiz       (pump_hiz[i])
        );
    end

    p_reset_float_r1: assert property (@(posedge clk)
        !rst_n |=> (pump_hiz == {NUM_CH{1'b1}}));
endmodule

// File: tb/tb_fb_clamp_ctrl.sv
module tb_fb_clamp_ctrl;
    localparam int NC = 3;
    localparam int W  = 8;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic                   clamp_off;
    logic                   clamp_gate;
    logic [NC-1:0][W-1:0]   smp_code;
    logic [NC-1:0]          smp_valid;
    logic [NC-1:0]          chroma_sel;
    logic [NC-1:0]          pump_charge, pump_discharge, pump_hiz;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_st [NC];   // 0 float, 1 charge, 2 discharge

    fb_clamp_ctrl dut (
        .clk(clk), .rst_n(rst_n), .clamp_off(clamp_off), .clamp_gate(clamp_gate),
        .smp_code(smp_code), .smp_valid(smp_valid), .chroma_sel(chroma_sel),
        .pump_charge(pump_charge), .pump_discharge(pump_discharge), .pump_hiz(pump_hiz)
    );

    always #4 clk = ~clk;

    function automatic int model(input int code, input bit sel);
        int t;
        t = sel ? 128 : 16;
        if (code < t) return 1;
        if (code > t) return 2;
        return 0;
    endfunction

    task automatic check_lanes(input string req);
        for (int c = 0; c < NC; c++) begin
            logic [2:0] act, exp;
            act = {pump_hiz[c], pump_discharge[c], pump_charge[c]};
            exp = (exp_st[c] == 1) ? 3'b001 : (exp_st[c] == 2) ? 3'b010 : 3'b100;
            n_chk++;
            if (act !== exp) begin
                n_fail++;
                $display("FAIL %s lane %0d: actual hiz/dis/chg=%b expected=%b", req, c, act, exp);
            end
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        rst_n = 1'b0; clamp_off = 1'b0; clamp_gate = 1'b0;
        smp_code = '0; smp_valid = '0; chroma_sel = 3'b110;
        for (int c = 0; c < NC; c++) exp_st[c] = 0;
        step(); step();
        check_lanes("R1 in reset");
        rst_n = 1'b1;
        step();
        check_lanes("R1 after reset");

        // R2 R3 R4 R5 R10: exhaustive codes, both targets, one lane at a time
        clamp_gate = 1'b1;
        for (int c = 0; c < NC; c++) begin
            for (int s = 0; s < 2; s++) begin
                chroma_sel[c] = s[0];
                for (int v = 0; v < 256; v++) begin
                    smp_valid = '0;
                    smp_valid[c] = 1'b1;
                    smp_code[c] = W'(v);
                    for (int o = 0; o < NC; o++) if (o != c) smp_code[o] = W'(255 - v);
                    step();
                    exp_st[c] = model(v, s[0]);
                    check_lanes("R2/R3/R4/R5/R10 sweep");
                end
            end
        end
        chroma_sel = 3'b110;

        // R8: valid low, code moves, state kept
        smp_valid = 3'b111;
        smp_code[0] = 8'd0; smp_code[1] = 8'd255; smp_code[2] = 8'd128;
        step();
        exp_st[0] = 1; exp_st[1] = 2; exp_st[2] = 0;
        check_lanes("R2/R4 setup");
        smp_valid = '0;
        for (int k = 0; k < 4; k++) begin
            smp_code[0] = 8'(200 + k); smp_code[1] = 8'(k); smp_code[2] = 8'(k * 60);
            step();
            check_lanes("R8 stall keeps command");
        end

        // R6 collision: gate closes with valid charging sample
        smp_valid = 3'b111;
        smp_code[0] = 8'd3; smp_code[1] = 8'd250; smp_code[2] = 8'd0;
        clamp_gate = 1'b0;
        step();
        for (int c = 0; c < NC; c++) exp_st[c] = 0;
        check_lanes("R6 gate closed with valid sample");
        step();
        check_lanes("R6 gate stays closed");

        // R7 collision: reopen, then clamp-off rises with valid samples
        clamp_gate = 1'b1;
        step();
        exp_st[0] = 1; exp_st[1] = 2; exp_st[2] = 1;
        check_lanes("R2/R4 reopen");
        clamp_off = 1'b1;
        step();
        for (int c = 0; c < NC; c++) exp_st[c] = 0;
        check_lanes("R7 clamp-off with open gate");
        smp_code[0] = 8'd255;
        step();
        check_lanes("R7 clamp-off held");
        clamp_off = 1'b0;
        step();
        exp_st[0] = 2; exp_st[1] = 2; exp_st[2] = 1;
        check_lanes("R4 after clamp-off released");

        // R1 again: reset in the middle of activity
        rst_n = 1'b0;
        step();
        for (int c = 0; c < NC; c++) exp_st[c] = 0;
        check_lanes("R1 mid-run reset");
        rst_n = 1'b1;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule